// File: doc/BRIEF.md
# Multi-Size Translation Cache

This block keeps a small, fully associative set of address translations for a processor memory path. Each slot maps one virtual page to one physical frame. The slot also records a page-size code, an address-space tag and a protection-group number, together with a valid flag and a pinned flag. A lookup compares the presented virtual address against every slot at the same time. Each slot ignores the low address bits that fall inside its own page size. A hit returns the physical address, formed from the slot's frame bits and the untranslated offset bits of the request, along with the slot's protection group.

A miss is only flagged. Software services it by writing a replacement slot through the write port. Slots are filled in round-robin order, and pinned slots are skipped. When every slot is pinned, a write is discarded. Software can flush all unpinned slots at once, or remove the slots that cover one given address, pinned or not. When translation is switched off, the address passes through unchanged and neither hit nor miss is raised. The lookup path is combinational from the request inputs and the stored state. All updates take effect at the rising clock edge.

Top module: `tlb_multisize`

## Requirements
- R1: After reset every slot is invalid, so an enabled lookup reports a miss and no hit.
- R2: A lookup hits a slot only when that slot is valid, its address-space tag equals asid_i, and va_i equals the slot's virtual address above the slot's offset bits. On a hit, pa_o takes bits above the offset from the slot's frame and the offset bits from va_i.
- R3: The page-size code selects how many low bits are excluded from the compare and passed through untranslated: code 0 gives 12 bits, code 1 gives 14, code 2 gives 19 and code 3 gives 23.
- R4: On a hit, group_o carries the 4-bit protection group of the winning slot. Otherwise group_o is zero.
- R5: With translation on and req_i high, miss_o is raised exactly when no slot hits, and pa_o then equals va_i. With req_i low, neither hit_o nor miss_o is raised.
- R6: With xlat_en_i low, pa_o equals va_i, and hit_o and miss_o are both low.
- R7: A write fills the first slot that is not both valid and pinned, searching upward with wrap-around from a rotating pointer. After the write, the pointer moves to the slot just past the one written. Starting from reset with no pins, the ninth write replaces the first slot written.
- R8: When all slots are valid and pinned, a write changes nothing.
- R9: A flush-all clears every slot that is not pinned and leaves pinned slots able to hit.
- R10: A single invalidate clears, and unpins, every valid slot whose page (at that slot's own size) contains inv_va_i, whatever its address-space tag.
- R11: When several slots hit, the lowest-numbered one supplies pa_o and group_o.
- R12: When updates share a clock edge, the invalidations are applied first and the write second. The write slot is chosen from the state before the edge. A lookup in that cycle still sees the state before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xlat_en_i | input | 1 | Translation enable |
| req_i | input | 1 | Lookup request |
| va_i | input | 32 | Lookup virtual address |
| asid_i | input | 4 | Current address-space tag |
| hit_o | output | 1 | Lookup hit |
| miss_o | output | 1 | Lookup miss, for software reload |
| pa_o | output | 32 | Translated or passed-through address |
| group_o | output | 4 | Protection group of the winning slot |
| wr_en_i | input | 1 | Write one slot |
| wr_va_i | input | 32 | Virtual page address written |
| wr_pa_i | input | 32 | Physical frame address written |
| wr_size_i | input | 2 | Page-size code written |
| wr_asid_i | input | 4 | Address-space tag written |
| wr_group_i | input | 4 | Protection group written |
| wr_lock_i | input | 1 | Pin the written slot |
| inv_all_i | input | 1 | Flush all unpinned slots |
| inv_one_i | input | 1 | Invalidate slots covering inv_va_i |
| inv_va_i | input | 32 | Address for single invalidate |

## Verification
The collision that matters is a write arriving on the same edge as a flush or a single invalidate, with a lookup of the written address presented in that same cycle. Directed steps raise write, flush and invalidate together on an address already resident. The random phase also raises them independently, so they coincide often. A bench model applies the invalidations, then the write, using the write slot chosen before the edge. It compares the lookup outputs both in the colliding cycle, where the old contents must still be visible, and in the cycle after it.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    PG_4K   = 2'd0,
    PG_16K  = 2'd1,
    PG_512K = 2'd2,
    PG_8M   = 2'd3
  } pg_size_e;

  // untranslated low bits per page-size code
  function automatic logic [4:0] offset_bits(logic [1:0] code);
    case (pg_size_e'(code))
      PG_4K:   offset_bits = 5'd12;
      PG_16K:  offset_bits = 5'd14;
      PG_512K: offset_bits = 5'd19;
      default: offset_bits = 5'd23;
    endcase
  endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match import tlb_pkg::*; #(
  parameter int N_ENTRIES  = 8,
  parameter int VA_W       = 32,
  parameter int ASID_W     = 4,
  parameter bit CHECK_ASID = 1'b1,
  localparam int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [N_ENTRIES-1:0]              valid_i,
  input  logic [N_ENTRIES-1:0][VA_W-1:0]    va_tab_i,
  input  logic [N_ENTRIES-1:0][1:0]         size_tab_i,
  input  logic [N_ENTRIES-1:0][ASID_W-1:0]  asid_tab_i,
  input  logic [VA_W-1:0]                   va_i,
  input  logic [ASID_W-1:0]                 asid_i,
  output logic [N_ENTRIES-1:0]              match_o,
  output logic                              any_o,
  output logic [IDX_W-1:0]                  first_o
);

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    logic [VA_W-1:0] mask;
    logic            addr_eq;
    assign mask    = {VA_W{1'b1}} << offset_bits(size_tab_i[g]);
    assign addr_eq = ((va_i ^ va_tab_i[g]) & mask) == '0;
    if (CHECK_ASID) begin : g_asid
      assign match_o[g] = valid_i[g] && addr_eq && (asid_tab_i[g] == asid_i);
    end else begin : g_noasid
      assign match_o[g] = valid_i[g] && addr_eq;
    end
  end

  assign any_o = |match_o;

  always_comb begin
    first_o = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (match_o[i]) first_o = IDX_W'(i);
    end
  end

  // R11
  lowest_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (match_o[first_o] &&
               ((match_o & ~({N_ENTRIES{1'b1}} << first_o)) == '0)));

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N_ENTRIES = 8,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_ENTRIES-1:0] pinned_i,
  input  logic                 wr_en_i,
  output logic [IDX_W-1:0]     victim_o,
  output logic                 have_o
);

  logic [IDX_W-1:0] rr_q;

  always_comb begin
    victim_o = '0;
    have_o   = 1'b0;
    for (int k = 0; k < N_ENTRIES; k++) begin
      int idx;
      idx = (int'(rr_q) + k) % N_ENTRIES;
      if (!have_o && !pinned_i[idx]) begin
        victim_o = IDX_W'(idx);
        have_o   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (wr_en_i && have_o) begin
      rr_q <= (int'(victim_o) == N_ENTRIES - 1) ? '0 : victim_o + 1'b1;
    end
  end

  // R7
  victim_unpinned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    have_o |-> !pinned_i[victim_o]);

  // R8
  no_victim_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !have_o |-> (&pinned_i));

endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int N_ENTRIES = 8,
  parameter int VA_W      = 32,
  parameter int ASID_W    = 4,
  parameter int GRP_W     = 4,
  localparam int IDX_W    = $clog2(N_ENTRIES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic                              have_victim_i,
  input  logic [IDX_W-1:0]                  victim_i,
  input  logic [VA_W-1:0]                   wr_va_i,
  input  logic [VA_W-1:0]                   wr_pa_i,
  input  logic [1:0]                        wr_size_i,
  input  logic [ASID_W-1:0]                 wr_asid_i,
  input  logic [GRP_W-1:0]                  wr_group_i,
  input  logic                              wr_lock_i,
  input  logic                              inv_all_i,
  input  logic                              inv_one_i,
  input  logic [N_ENTRIES-1:0]              inv_hit_i,
  output logic [N_ENTRIES-1:0]              valid_o,
  output logic [N_ENTRIES-1:0]              pinned_o,
  output logic [N_ENTRIES-1:0][VA_W-1:0]    va_o,
  output logic [N_ENTRIES-1:0][VA_W-1:0]    pa_o,
  output logic [N_ENTRIES-1:0][1:0]         size_o,
  output logic [N_ENTRIES-1:0][ASID_W-1:0]  asid_o,
  output logic [N_ENTRIES-1:0][GRP_W-1:0]   group_o
);

  logic [N_ENTRIES-1:0] valid_q, lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      lock_q  <= '0;
      va_o    <= '0;
      pa_o    <= '0;
      size_o  <= '0;
      asid_o  <= '0;
      group_o <= '0;
    end else begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (inv_all_i && !lock_q[i]) valid_q[i] <= 1'b0;
        if (inv_one_i && inv_hit_i[i]) begin
          valid_q[i] <= 1'b0;
          lock_q[i]  <= 1'b0;
        end
      end
      // write lands after invalidations
      if (wr_en_i && have_victim_i) begin
        valid_q[victim_i] <= 1'b1;
        lock_q[victim_i]  <= wr_lock_i;
        va_o[victim_i]    <= wr_va_i;
        pa_o[victim_i]    <= wr_pa_i;
        size_o[victim_i]  <= wr_size_i;
        asid_o[victim_i]  <= wr_asid_i;
        group_o[victim_i] <= wr_group_i;
      end
    end
  end

  assign valid_o  = valid_q;
  assign pinned_o = valid_q & lock_q;

  // R7
  write_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && have_victim_i) |=> valid_q[$past(victim_i)]);

  // R8
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (&pinned_o) && !inv_one_i) |=> $stable(valid_q) && $stable(va_o));

  // R9
  flush_keeps_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_all_i && !inv_one_i && !wr_en_i) |=> valid_q == $past(valid_q & lock_q));

endmodule

// File: rtl/tlb_multisize.sv
module tlb_multisize import tlb_pkg::*; #(
  parameter int N_ENTRIES = 8,
  parameter int VA_W      = 32,
  parameter int ASID_W    = 4,
  parameter int GRP_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xlat_en_i,
  input  logic              req_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic [ASID_W-1:0] asid_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [VA_W-1:0]   pa_o,
  output logic [GRP_W-1:0]  group_o,
  input  logic              wr_en_i,
  input  logic [VA_W-1:0]   wr_va_i,
  input  logic [VA_W-1:0]   wr_pa_i,
  input  logic [1:0]        wr_size_i,
  input  logic [ASID_W-1:0] wr_asid_i,
  input  logic [GRP_W-1:0]  wr_group_i,
  input  logic              wr_lock_i,
  input  logic              inv_all_i,
  input  logic              inv_one_i,
  input  logic [VA_W-1:0]   inv_va_i
);

  localparam int IDX_W = $clog2(N_ENTRIES);

  logic [N_ENTRIES-1:0]              valid, pinned, look_match, inv_match;
  logic [N_ENTRIES-1:0][VA_W-1:0]    tab_va, tab_pa;
  logic [N_ENTRIES-1:0][1:0]         tab_size;
  logic [N_ENTRIES-1:0][ASID_W-1:0]  tab_asid;
  logic [N_ENTRIES-1:0][GRP_W-1:0]   tab_grp;
  logic [IDX_W-1:0]                  victim, look_idx, inv_idx;
  logic                              have_victim, look_any, inv_any;
  logic                              active, hit;
  logic [VA_W-1:0]                   pg_mask;

  tlb_victim #(.N_ENTRIES(N_ENTRIES)) i_victim (
    .clk_i, .rst_ni,
    .pinned_i (pinned),
    .wr_en_i,
    .victim_o (victim),
    .have_o   (have_victim)
  );

  tlb_store #(
    .N_ENTRIES(N_ENTRIES), .VA_W(VA_W), .ASID_W(ASID_W), .GRP_W(GRP_W)
  ) i_store (
    .clk_i, .rst_ni,
    .wr_en_i,
    .have_victim_i (have_victim),
    .victim_i      (victim),
    .wr_va_i, .wr_pa_i, .wr_size_i, .wr_asid_i, .wr_group_i, .wr_lock_i,
    .inv_all_i, .inv_one_i,
    .inv_hit_i     (inv_match),
    .valid_o       (valid),
    .pinned_o      (pinned),
    .va_o          (tab_va),
    .pa_o          (tab_pa),
    .size_o        (tab_size),
    .asid_o        (tab_asid),
    .group_o       (tab_grp)
  );

  tlb_match #(
    .N_ENTRIES(N_ENTRIES), .VA_W(VA_W), .ASID_W(ASID_W), .CHECK_ASID(1'b1)
  ) i_look (
    .clk_i, .rst_ni,
    .valid_i    (valid),
    .va_tab_i   (tab_va),
    .size_tab_i (tab_size),
    .asid_tab_i (tab_asid),
    .va_i       (va_i),
    .asid_i     (asid_i),
    .match_o    (look_match),
    .any_o      (look_any),
    .first_o    (look_idx)
  );

  // single invalidate ignores the address-space tag
  tlb_match #(
    .N_ENTRIES(N_ENTRIES), .VA_W(VA_W), .ASID_W(ASID_W), .CHECK_ASID(1'b0)
  ) i_inv (
    .clk_i, .rst_ni,
    .valid_i    (valid),
    .va_tab_i   (tab_va),
    .size_tab_i (tab_size),
    .asid_tab_i (tab_asid),
    .va_i       (inv_va_i),
    .asid_i     ('0),
    .match_o    (inv_match),
    .any_o      (inv_any),
    .first_o    (inv_idx)
  );

  assign active  = xlat_en_i && req_i;
  assign hit     = active && look_any;
  assign pg_mask = {VA_W{1'b1}} << offset_bits(tab_size[look_idx]);

  assign hit_o   = hit;
  assign miss_o  = active && !look_any;
  assign pa_o    = hit ? ((tab_pa[look_idx] & pg_mask) | (va_i & ~pg_mask)) : va_i;
  assign group_o = hit ? tab_grp[look_idx] : '0;

  // R5
  hit_miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o));

  // R6
  off_passthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xlat_en_i |-> (pa_o == va_i && !hit_o && !miss_o));

  // R10
  inv_one_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_one_i && inv_any && !wr_en_i) |=> !valid[$past(inv_idx)]);

  // R2
  hit_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (valid[look_idx] && tab_asid[look_idx] == asid_i));

endmodule

// File: tb/test_tlb_multisize.sv
module test_tlb_multisize;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, req = 1'b0;
  logic [31:0] va = '0;
  logic [3:0]  asid = '0;
  logic        hit, miss;
  logic [31:0] pa;
  logic [3:0]  grp;
  logic        wr = 1'b0;
  logic [31:0] wva = '0, wpa = '0;
  logic [1:0]  wsz = '0;
  logic [3:0]  wasid = '0, wgrp = '0;
  logic        wlock = 1'b0;
  logic        iall = 1'b0, ione = 1'b0;
  logic [31:0] iva = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tlb_multisize i_tlb_multisize (
    .clk_i(clk), .rst_ni(rst_n), .xlat_en_i(en), .req_i(req), .va_i(va),
    .asid_i(asid), .hit_o(hit), .miss_o(miss), .pa_o(pa), .group_o(grp),
    .wr_en_i(wr), .wr_va_i(wva), .wr_pa_i(wpa), .wr_size_i(wsz),
    .wr_asid_i(wasid), .wr_group_i(wgrp), .wr_lock_i(wlock),
    .inv_all_i(iall), .inv_one_i(ione), .inv_va_i(iva)
  );

  // reference model
  bit          m_v[N], m_l[N];
  logic [31:0] m_va[N], m_pa[N];
  logic [1:0]  m_sz[N];
  logic [3:0]  m_as[N], m_gr[N];
  int          m_rr;

  function automatic logic [31:0] pmask(logic [1:0] s);
    int sh;
    sh = (s == 0) ? 12 : (s == 1) ? 14 : (s == 2) ? 19 : 23;
    return 32'hFFFF_FFFF << sh;
  endfunction

  task automatic model_look(output bit h, output bit ms, output logic [31:0] p,
                            output logic [3:0] g);
    h = 0; ms = 0; p = va; g = '0;
    if (en && req) begin
      for (int i = 0; i < N; i++) begin
        if (!h && m_v[i] && m_as[i] == asid && ((va ^ m_va[i]) & pmask(m_sz[i])) == 0) begin
          h = 1;
          p = (m_pa[i] & pmask(m_sz[i])) | (va & ~pmask(m_sz[i]));
          g = m_gr[i];
        end
      end
      ms = !h;
    end
  endtask

  task automatic model_edge();
    int vic;
    bit im[N];
    vic = -1;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (m_rr + k) % N;
      if (vic < 0 && !(m_v[idx] && m_l[idx])) vic = idx;
    end
    for (int i = 0; i < N; i++)
      im[i] = m_v[i] && (((iva ^ m_va[i]) & pmask(m_sz[i])) == 0);
    for (int i = 0; i < N; i++) begin
      if (iall && !m_l[i]) m_v[i] = 0;
      if (ione && im[i]) begin m_v[i] = 0; m_l[i] = 0; end
    end
    if (wr && vic >= 0) begin
      m_v[vic] = 1; m_l[vic] = wlock; m_va[vic] = wva; m_pa[vic] = wpa;
      m_sz[vic] = wsz; m_as[vic] = wasid; m_gr[vic] = wgrp;
      m_rr = (vic + 1) % N;
    end
  endtask

  task automatic check(string tag);
    bit eh, em;
    logic [31:0] ep;
    logic [3:0] eg;
    model_look(eh, em, ep, eg);
    n_chk++;
    if (hit !== eh || miss !== em || pa !== ep || grp !== eg) begin
      n_bad++;
      $display("FAIL %s: va=%h asid=%0d got hit=%b miss=%b pa=%h grp=%h exp hit=%b miss=%b pa=%h grp=%h",
               tag, va, asid, hit, miss, pa, grp, eh, em, ep, eg);
    end
  endtask

  task automatic idle();
    wr = 0; iall = 0; ione = 0; wlock = 0;
  endtask

  // inputs held at negedge; check lookup, take edge, update model
  task automatic step(string tag);
    #1 check(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    idle();
  endtask

  task automatic do_wr(logic [31:0] a, logic [31:0] p, logic [1:0] s,
                       logic [3:0] as, logic [3:0] g, logic lk);
    wr = 1; wva = a; wpa = p; wsz = s; wasid = as; wgrp = g; wlock = lk;
    step("R7");
  endtask

  task automatic look(logic [31:0] a, logic [3:0] as, string tag);
    va = a; asid = as; en = 1; req = 1;
    #1 check(tag);
  endtask

  task automatic do_reset();
    rst_n = 0; idle();
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_l[i] = 0; end
    m_rr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no finish expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) begin
      m_va[i] = '0; m_pa[i] = '0; m_sz[i] = '0; m_as[i] = '0; m_gr[i] = '0;
    end
    @(negedge clk);
    do_reset();

    // R1: empty after reset
    look(32'h0000_1234, 4'd0, "R1");
    look(32'h0380_0000, 4'd3, "R1");

    // R3 / R2 / R4: one slot of each size, probe inside and just outside the page
    for (int s = 0; s < 4; s++) begin
      logic [31:0] base;
      base = 32'h1000_0000 * (s + 1);
      do_wr(base, 32'hA000_0000 + 32'h0100_0000 * s, 2'(s), 4'd2, 4'(s + 5), 1'b0);
      look(base | ~pmask(2'(s)), 4'd2, "R3");
      look(base + (~pmask(2'(s)) + 1), 4'd2, "R3");
      look(base, 4'd2, "R4");
      look(base, 4'd1, "R2");
    end

    // R6: disabled passes through
    en = 0; va = 32'h1000_0ABC; #1 check("R6");
    // R5: req low, then enabled miss
    en = 1; req = 0; #1 check("R5");
    look(32'h7777_7000, 4'd2, "R5");

    // R11: two slots covering the same address, lower index wins
    do_reset();
    do_wr(32'h0040_0000, 32'h1111_1000, 2'd0, 4'd0, 4'd1, 1'b0);
    do_wr(32'h0000_0000, 32'h2222_2000, 2'd3, 4'd0, 4'd2, 1'b0);
    look(32'h0040_0123, 4'd0, "R11");

    // R7: ninth write replaces slot 0
    do_reset();
    for (int i = 0; i < 9; i++)
      do_wr(32'h0010_0000 * i, 32'h5000_0000 + 32'h1000 * i, 2'd0, 4'd0, 4'(i), 1'b0);
    look(32'h0000_0010, 4'd0, "R7");
    look(32'h0080_0010, 4'd0, "R7");
    look(32'h0010_0010, 4'd0, "R7");

    // R8: pin all, then an extra write is dropped
    do_reset();
    for (int i = 0; i < N; i++)
      do_wr(32'h0020_0000 * i, 32'h6000_0000 + 32'h1000 * i, 2'd0, 4'd1, 4'(i), 1'b1);
    do_wr(32'h0F00_0000, 32'h7000_0000, 2'd0, 4'd1, 4'd9, 1'b0);
    look(32'h0F00_0000, 4'd1, "R8");
    look(32'h0000_0000, 4'd1, "R8");

    // R9: flush keeps pins; R10: single invalidate removes a pinned slot
    do_wr(32'h0F00_0000, 32'h7000_0000, 2'd0, 4'd1, 4'd9, 1'b0);
    iall = 1; step("R9");
    look(32'h0020_0000, 4'd1, "R9");
    ione = 1; iva = 32'h0020_0FFF; asid = 4'd7; step("R10");
    look(32'h0020_0000, 4'd1, "R10");
    look(32'h0040_0000, 4'd1, "R10");

    // R12: write, flush and invalidate on one edge; lookup of the written address
    do_reset();
    do_wr(32'h0300_0000, 32'h8000_0000, 2'd2, 4'd0, 4'd3, 1'b0);
    look(32'h0300_0000, 4'd0, "R12");
    wr = 1; wva = 32'h0300_0000; wpa = 32'h9000_0000; wsz = 2'd1; wasid = 4'd0;
    wgrp = 4'd4; wlock = 0; iall = 1; ione = 1; iva = 32'h0300_0000;
    step("R12");
    look(32'h0300_0000, 4'd0, "R12");
    look(32'h0300_3FFF, 4'd0, "R12");

    // random phase
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      string tag;
      r = $urandom;
      wr = (r[3:0] < 4);
      wlock = (r[7:4] == 0);
      iall = (r[11:8] == 0);
      ione = (r[15:12] < 2);
      wva = ($urandom & 32'h0388_7000);
      wpa = $urandom;
      wsz = 2'($urandom);
      wasid = 4'($urandom % 2);
      wgrp = 4'($urandom);
      iva = ($urandom & 32'h0388_7FFF);
      en = ($urandom % 16) != 0;
      req = ($urandom % 8) != 0;
      va = ($urandom & 32'h0388_7FFF);
      asid = 4'($urandom % 2);
      tag = !en ? "R6" : !req ? "R5" : (wr && (iall || ione)) ? "R12" : "R2";
      step(tag);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule